// File: doc/BRIEF.md
# USB Low-Power Wakeup Event Capture Register

This block watches four USB port status inputs while the system sits in a low-power state. The inputs are VBUS-valid, session-valid, the two-bit line state and an active-low overcurrent pin. Each input first passes through a two-flop synchronizer. A registered copy of the synchronized value then acts as the "previous" value, and a change between the two counts as an event.

An event becomes a wakeup only when two conditions hold: that source's enable input is high, and the clock-stop request input is high. A wakeup sets a sticky status flag for its source. It also freezes a before/after snapshot of the value that caused it.

Software reads all flags and snapshots as one 32-bit word. It clears every flag at once by writing a 1 to bit 0. Only the first wakeup of a source after a clear updates that source's snapshot. Later changes leave the snapshot as it is until the next clear.

Top module: `usbwk_capture`

## Requirements
- R1: While the active-low reset `rst_n` is low, and right after it is released, `rd_data` reads 0.
- R2: The status flags sit in fixed bits of `rd_data`: VBUS-valid in bit 1, session-valid in bit 2, line state in bit 3, overcurrent in bit 4. `wake_en` uses bit 0 for VBUS-valid, bit 1 for session-valid, bit 2 for line state and bit 3 for overcurrent.
- R3: A flag cannot be set while its `wake_en` bit is 0.
- R4: No flag can be set while `clkstop_req` is 0.
- R5: A set flag stays set, even after its input returns to its old value, until software clears it.
- R6: A cycle with `wr_en`=1 and `wr_data[0]`=1 clears all four flags.
- R7: If a clear and a qualifying event of a source fall in the same cycle, that source's flag is set afterwards.
- R8: On a wakeup the snapshot fields capture the value before and after the change. VBUS-valid uses bit 5 for before and bit 6 for after. Session-valid uses bits 7 and 8. Line state uses bits 10:9 for before and 12:11 for after. Overcurrent uses bits 13 and 14.
- R9: While a source's flag is set and no clear is written, later changes of that input leave its snapshot unchanged.
- R10: A change in either bit of the line state is a line-state event.
- R11: Bits 31:15 and bit 0 of `rd_data` always read 0. A write with `wr_data[0]`=0 has no effect, whatever the other bits hold.
- R12: The overcurrent event comes from the pin `ovc_n_i`. A falling edge and a rising edge of the pin are both events.
- R13: A flag appears in `rd_data` after the third rising clock edge following a change of its input: two synchronizer stages, then the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low configuration soft reset |
| wake_en | input | 4 | Per-source wakeup enables |
| clkstop_req | input | 1 | Clock-stop request; high while in low power |
| vbus_valid_i | input | 1 | VBUS-valid port input |
| sess_valid_i | input | 1 | Session-valid port input |
| line_state_i | input | 2 | Line state port input |
| ovc_n_i | input | 1 | Active-low overcurrent pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bit 0 is write-1-to-clear |
| rd_data | output | 32 | Status and snapshot word |

## Verification
The hardest case to reach from the ports is a clear write that lands in exactly the same cycle as a new qualifying event. The event only becomes visible inside the block two edges after the input moves. The bench therefore counts edges from the input change and asserts the write strobe on the half cycle just before the third edge. After that write, the flag must still be set and the snapshot must show the new change. The first-event-only snapshot rule is also checked: an input is toggled back after a wakeup, and the bench confirms that the snapshot did not move.

// File: rtl/usbwk_pkg.sv
package usbwk_pkg;
  localparam int NSRC   = 4;   // sources: 0 vbus, 1 session, 2 line state, 3 overcurrent
  localparam int RAW_W  = 5;   // packed width of all source inputs
  localparam int WORD_W = 32;
  localparam int CLR_BIT = 0;

  // width of each source in bits
  function automatic int src_w(input int i);
    return (i == 2) ? 2 : 1;
  endfunction

  // offset of each source inside the packed input vector
  function automatic int src_off(input int i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      default: return 4;
    endcase
  endfunction

  // bit of the status flag in the read word
  function automatic int flag_bit(input int i);
    return 1 + i;
  endfunction

  // lowest bit of the "before" snapshot; "after" follows directly above it
  function automatic int snap_base(input int i);
    return 5 + 2 * src_off(i);
  endfunction
endpackage

// File: rtl/usbwk_sync.sv
module usbwk_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q        <= '0;
    end else begin
      stage1_q <= d;
      q        <= stage1_q;
    end
  end
endmodule

// File: rtl/usbwk_src.sv
module usbwk_src #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic         arm,
  input  logic         clr,
  output logic         evt,
  output logic         flag,
  output logic [W-1:0] snap_prev,
  output logic [W-1:0] snap_cur
);
  logic [W-1:0] prev_q;
  logic         first_w;

  assign evt     = arm && (cur != prev_q);
  assign first_w = !flag || clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      flag      <= 1'b0;
      snap_prev <= '0;
      snap_cur  <= '0;
    end else begin
      prev_q <= cur;
      if (evt)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (evt && first_w) begin
        snap_prev <= prev_q;
        snap_cur  <= cur;
      end
    end
  end
endmodule

// File: rtl/usbwk_capture.sv
module usbwk_capture
  import usbwk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   wake_en,
  input  logic              clkstop_req,
  input  logic              vbus_valid_i,
  input  logic              sess_valid_i,
  input  logic [1:0]        line_state_i,
  input  logic              ovc_n_i,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  logic [RAW_W-1:0] raw_w, sync_q, snap_p, snap_c;
  logic [NSRC-1:0]  evt_q, flag_q;
  logic             clr_w;

  assign raw_w = {ovc_n_i, line_state_i, sess_valid_i, vbus_valid_i};
  assign clr_w = wr_en && wr_data[CLR_BIT];

  usbwk_sync #(.W(RAW_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_w), .q(sync_q)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int W   = src_w(i);
    localparam int OFF = src_off(i);
    usbwk_src #(.W(W)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur      (sync_q[OFF +: W]),
      .arm      (wake_en[i] && clkstop_req),
      .clr      (clr_w),
      .evt      (evt_q[i]),
      .flag     (flag_q[i]),
      .snap_prev(snap_p[OFF +: W]),
      .snap_cur (snap_c[OFF +: W])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSRC; i++) begin
      rd_data[flag_bit(i)] = flag_q[i];
      for (int j = 0; j < src_w(i); j++) begin
        rd_data[snap_base(i) + j]            = snap_p[src_off(i) + j];
        rd_data[snap_base(i) + src_w(i) + j] = snap_c[src_off(i) + j];
      end
    end
  end
endmodule

// File: rtl/usbwk_capture_chk.sv
module usbwk_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  wake_en,
  input logic        clkstop_req,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic [3:0]  evt_q,
  input logic        clr_w
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:15] == 17'd0) && !rd_data[0]);  // R11

  AST_NO_SET_WO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !clkstop_req |=> ((rd_data[4:1] & ~$past(rd_data[4:1])) == 4'd0));  // R4

  AST_NO_SET_WO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data[4:1] & ~$past(rd_data[4:1]) & ~$past(wake_en)) == 4'd0));  // R3

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[0]) |=> ((rd_data[4:1] & $past(rd_data[4:1])) == $past(rd_data[4:1])));  // R5

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q != 4'd0) |=> ((rd_data[4:1] & $past(evt_q)) == $past(evt_q)));  // R7

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w && (evt_q == 4'd0)) |=> (rd_data[4:1] == 4'd0));  // R6

  AST_SNAP_HOLD_LS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] && !clr_w) |=> $stable(rd_data[12:9]));  // R9

  AST_SNAP_HOLD_VB: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] && !clr_w) |=> $stable(rd_data[6:5]));  // R9
endmodule

bind usbwk_capture usbwk_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wake_en(wake_en), .clkstop_req(clkstop_req),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .evt_q(evt_q), .clr_w(clr_w)
);

// File: tb/usbwk_capture_tb.sv
module usbwk_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wake_en = 4'd0;
  logic        clkstop_req = 1'b0;
  logic        vbus_valid_i = 1'b0;
  logic        sess_valid_i = 1'b0;
  logic [1:0]  line_state_i = 2'b00;
  logic        ovc_n_i = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] FLAGS = 32'h0000_001E;

  always #4 clk = ~clk;  // 125 MHz

  usbwk_capture u_dut (
    .clk(clk), .rst_n(rst_n), .wake_en(wake_en), .clkstop_req(clkstop_req),
    .vbus_valid_i(vbus_valid_i), .sess_valid_i(sess_valid_i),
    .line_state_i(line_state_i), .ovc_n_i(ovc_n_i),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] mask, input logic [31:0] exp);
    checks++;
    if ((rd_data & mask) !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h (mask %h)", req, rd_data & mask, exp, mask);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // three edges of latency (R13) plus one of margin
  task automatic settle();
    wait_n(4);
  endtask

  task automatic do_write(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'd0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset value", 32'hFFFF_FFFF, 32'd0);
    wait_n(5);
    check("R11 reserved and bit0 zero", 32'hFFFF_8001, 32'd0);
    check("R1 no flags after settle", FLAGS, 32'd0);
  endtask

  task automatic t_no_stop();
    wake_en = 4'hF; clkstop_req = 1'b0;
    vbus_valid_i = 1'b1; sess_valid_i = 1'b1; settle();
    check("R4 no capture without clock-stop", FLAGS, 32'd0);
    vbus_valid_i = 1'b0; sess_valid_i = 1'b0; settle();
  endtask

  task automatic t_no_en();
    wake_en = 4'h0; clkstop_req = 1'b1;
    sess_valid_i = 1'b1; line_state_i = 2'b11; settle();
    check("R3 no capture without enable", FLAGS, 32'd0);
    sess_valid_i = 1'b0; line_state_i = 2'b00; settle();
  endtask

  task automatic t_latency();
    wake_en = 4'b0001;
    @(negedge clk); vbus_valid_i = 1'b1;
    wait_n(2);
    check("R13 flag not yet visible after two edges", FLAGS, 32'd0);
    wait_n(1);
    check("R13 flag visible after third edge", FLAGS, 32'h2);
    check("R2 R8 vbus flag bit1, before bit5=0, after bit6=1", 32'h0000_007E, 32'h0000_0042);
  endtask

  task automatic t_sticky();
    vbus_valid_i = 1'b0; settle();
    check("R5 flag stays set after input returns", FLAGS, 32'h2);
    check("R9 snapshot unchanged by later change", 32'h0000_0060, 32'h0000_0040);
    do_write(32'hFFFF_FFFE);
    check("R11 write without bit0 has no effect", 32'hFFFF_FFFF, 32'h0000_0042);
  endtask

  task automatic t_clear();
    do_write(32'h0000_0001);
    check("R6 write-1 to bit0 clears flags", FLAGS, 32'd0);
  endtask

  task automatic t_line();
    wake_en = 4'b0100;
    line_state_i = 2'b10; settle();
    check("R10 line upper bit change: flag bit3, before 00, after 10",
          32'h0000_1E1E, 32'h0000_1008);
    do_write(32'h1);
    line_state_i = 2'b01; settle();
    check("R10 line both bits change: before 10, after 01",
          32'h0000_1E1E, 32'h0000_0C08);
    do_write(32'h1);
    line_state_i = 2'b00; settle();
    check("R10 line lower bit change only", 32'h0000_1E1E, 32'h0000_0208);
    do_write(32'h1);
  endtask

  task automatic t_ovc();
    wake_en = 4'b1000;
    ovc_n_i = 1'b0; settle();
    check("R12 R2 overcurrent fall: flag bit4, before bit13=1, after bit14=0",
          32'h0000_601E, 32'h0000_2010);
    do_write(32'h1);
    ovc_n_i = 1'b1; settle();
    check("R12 overcurrent rise: before 0, after 1", 32'h0000_601E, 32'h0000_4010);
    do_write(32'h1);
  endtask

  task automatic t_sess();
    wake_en = 4'b0010;
    sess_valid_i = 1'b1; settle();
    check("R2 R8 session flag bit2, before bit7=0, after bit8=1",
          32'h0000_019E, 32'h0000_0104);
    do_write(32'h1);
    sess_valid_i = 1'b0; settle();
    do_write(32'h1);
  endtask

  task automatic t_same_cycle();
    wake_en = 4'b0001;
    vbus_valid_i = 1'b1; settle();
    check("R7 setup flag set", FLAGS, 32'h2);
    @(negedge clk); vbus_valid_i = 1'b0;
    @(posedge clk); @(posedge clk);   // event now visible inside
    @(negedge clk); wr_en = 1'b1; wr_data = 32'h1;
    @(negedge clk); wr_en = 1'b0; wr_data = 32'h0;
    check("R7 event wins over same-cycle clear", FLAGS, 32'h2);
    check("R7 snapshot taken from the new event", 32'h0000_0060, 32'h0000_0020);
    do_write(32'h1);
    check("R6 clear without event", FLAGS, 32'd0);
  endtask

  initial begin
    wait_n(3);
    check("R1 value during reset", 32'hFFFF_FFFF, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_no_stop();
    t_no_en();
    t_latency();
    t_sticky();
    t_clear();
    t_line();
    t_ovc();
    t_sess();
    t_same_cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule